// File: doc/BRIEF.md
# External Bus Write Sequencer

This block performs single write transfers on an external asynchronous memory bus. A host presents an address, a data word and three phase lengths (setup, strobe and hold, called lead, active and trail here) through a valid/ready handshake. The block then walks the bus through the three phases. During the whole transfer it holds the chip-select low and the read/not-write line low. It pulls the write strobe low for the active phase. It drives the data bus from the moment the strobe falls until the hold phase ends.

A ready line from the memory side can stretch the active phase by whole cycles. The ready line works in one of two modes. In synchronous mode the line is sampled directly. In asynchronous mode it first passes through a two-flop synchronizer, so the raw pin is in effect first looked at two cycles earlier than in synchronous mode. Between transfers the address bus keeps the last address it drove. The data-bus output enable is a separate pin so that the pad ring can build the tri-state driver.

States: `WS_IDLE` (waiting for a request), `WS_LEAD` (select and address set up, strobe high), `WS_ACTIVE` (strobe low for the programmed count), `WS_WAIT` (strobe held low while ready is low) and `WS_TRAIL` (strobe high, data still driven). Transitions:
- IDLE→LEAD on an accepted request.
- LEAD→ACTIVE when the lead count runs out.
- ACTIVE→TRAIL when the active count runs out and ready is high.
- ACTIVE→WAIT when the active count runs out and ready is low.
- WAIT→TRAIL on the first cycle ready is seen high.
- TRAIL→IDLE when the trail count runs out.

Top module: `ext_wr_seq`

## Requirements
- R1: After reset, bus_cs_n, bus_we_n and bus_rnw are 1, bus_dq_oe and wr_done are 0, bus_addr is 0 and req_ready is 1.
- R2: A request is accepted on the rising edge where req_valid and req_ready are both 1. Call that edge 0. bus_cs_n is 0 in cycles 1 to L+A+W+T and 1 afterwards. bus_we_n is 0 exactly in cycles L+1 to L+A+W. Here L, A and T are the lead, active and trail counts and W is the number of wait cycles.
- R3: bus_rnw is 0 in exactly the cycles where bus_cs_n is 0, and is never 1 while bus_dq_oe is 1.
- R4: bus_dq_oe is 1 exactly in cycles L+1 to L+A+W+T. While it is 1, bus_dq_o equals the accepted data word and does not change.
- R5: With cfg_rdy_async = 0, bus_rdy is first sampled on edge L+A. If bus_rdy is 0 there, the block checks it again on every following edge. W equals the number of edges that saw bus_rdy low.
- R6: With cfg_rdy_async = 1, the value used on edge n is the value bus_rdy had at edge n-2. The first sample of the pin therefore falls on edge L+A-2, and a ready that rises at edge R gives W = max(0, R+2-(L+A)).
- R7: bus_addr changes only on an accepted request. Between transfers it keeps the last address and ignores req_addr.
- R8: A lead, active or trail count of 0 is treated as 1.
- R9: wr_done is 1 for exactly one cycle, cycle L+A+W+T. req_ready is 0 from cycle 1 through that cycle. A request held valid is accepted on the edge that ends the following cycle.
- R10: The counts, the ready mode, the address and the data are captured on edge 0. Changes on cfg_*, req_addr or req_data during a transfer have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| cfg_lead | input | CW | Lead phase length in cycles |
| cfg_active | input | CW | Active phase length in cycles |
| cfg_trail | input | CW | Trail phase length in cycles |
| cfg_rdy_async | input | 1 | 1: ready goes through the synchronizer |
| bus_rdy | input | 1 | External ready, high = access may finish |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_rnw | output | 1 | Read/not-write, low for writes |
| bus_addr | output | AW | Address bus |
| bus_dq_o | output | DW | Data bus output value |
| bus_dq_oe | output | 1 | Data bus output enable |
| wr_done | output | 1 | One-cycle pulse in the last trail cycle |

## Verification
The ready decision can fall in the same cycle as the rise of the ready line. The bench provokes this in both modes. In synchronous mode it raises bus_rdy exactly for edge L+A. In asynchronous mode it raises bus_rdy exactly for edge L+A-2. In both cases it expects no wait cycle, and it judges the result by the length of the write strobe and of chip-select. A second coincidence is the done pulse of one transfer and a request that has been held valid throughout. Here the bench checks that req_ready stays low up to and including the done cycle. It also checks that chip-select is high for exactly one cycle before the next transfer, which must carry the new address.

// File: rtl/ext_wr_pkg.sv
package ext_wr_pkg;

    typedef enum logic [2:0] {
        WS_IDLE   = 3'd0,
        WS_LEAD   = 3'd1,
        WS_ACTIVE = 3'd2,
        WS_WAIT   = 3'd3,
        WS_TRAIL  = 3'd4
    } wr_state_e;

endpackage

// File: rtl/ext_wr_cfg_latch.sv
module ext_wr_cfg_latch #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] lead_in,
    input  logic [CW-1:0] act_in,
    input  logic [CW-1:0] trail_in,
    input  logic          async_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [CW-1:0] lead_ld,
    output logic [CW-1:0] act_q,
    output logic [CW-1:0] trail_q,
    output logic          async_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] act_cl;
    logic [CW-1:0] trail_cl;

    // zero-length phases become one cycle long
    always_comb begin
        lead_ld  = (lead_in  == '0) ? ONE : lead_in;
        act_cl   = (act_in   == '0) ? ONE : act_in;
        trail_cl = (trail_in == '0) ? ONE : trail_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= ONE;
            trail_q <= ONE;
            async_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (load) begin
            act_q   <= act_cl;
            trail_q <= trail_cl;
            async_q <= async_in;
            addr_q  <= addr_in;
            data_q  <= data_in;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({act_q, trail_q, async_q, data_q})); // R10

    AST_PHASE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != '0) && (trail_q != '0)); // R8

endmodule

// File: rtl/ext_wr_rdy_sync.sv
module ext_wr_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_raw,
    input  logic async_mode,
    output logic rdy_eff
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= rdy_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    // synchronous mode samples the pin directly at the deciding edge
    assign rdy_eff = async_mode ? chain[STAGES-1] : rdy_raw;

endmodule

// File: rtl/ext_wr_fsm.sv
module ext_wr_fsm
    import ext_wr_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] lead_ld,
    input  logic [CW-1:0] act_q,
    input  logic [CW-1:0] trail_q,
    input  logic          rdy_eff,
    output logic          idle,
    output logic          cs_n,
    output logic          we_n,
    output logic          rnw,
    output logic          dq_oe,
    output logic          done
);

    localparam logic [CW-1:0] ONE = CW'(1);

    wr_state_e     state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WS_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            WS_IDLE: begin
                if (start) begin
                    state_nxt = WS_LEAD;
                    cnt_nxt   = lead_ld - ONE;
                end
            end
            WS_LEAD: begin
                if (cnt == '0) begin
                    state_nxt = WS_ACTIVE;
                    cnt_nxt   = act_q - ONE;
                end else begin
                    cnt_nxt = cnt - ONE;
                end
            end
            WS_ACTIVE: begin
                if (cnt != '0) begin
                    cnt_nxt = cnt - ONE;
                end else if (rdy_eff) begin
                    state_nxt = WS_TRAIL;
                    cnt_nxt   = trail_q - ONE;
                end else begin
                    state_nxt = WS_WAIT;
                end
            end
            WS_WAIT: begin
                if (rdy_eff) begin
                    state_nxt = WS_TRAIL;
                    cnt_nxt   = trail_q - ONE;
                end
            end
            WS_TRAIL: begin
                if (cnt == '0) state_nxt = WS_IDLE;
                else           cnt_nxt   = cnt - ONE;
            end
            default: begin
                state_nxt = WS_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        idle  = 1'b0;
        cs_n  = 1'b0;
        we_n  = 1'b1;
        rnw   = 1'b0;
        dq_oe = 1'b0;
        done  = 1'b0;
        unique case (state)
            WS_IDLE: begin
                idle = 1'b1;
                cs_n = 1'b1;
                rnw  = 1'b1;
            end
            WS_LEAD: begin
            end
            WS_ACTIVE, WS_WAIT: begin
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            WS_TRAIL: begin
                dq_oe = 1'b1;
                done  = (cnt == '0);
            end
            default: begin
                cs_n = 1'b1;
                rnw  = 1'b1;
            end
        endcase
    end

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_WAIT && !rdy_eff) |=> (state == WS_WAIT)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (idle && !done)); // R9

    AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n); // R2

    AST_LEAD_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_LEAD && cnt == '0) |=> (state == WS_ACTIVE && !we_n)); // R2

endmodule

// File: rtl/ext_wr_seq.sv
module ext_wr_seq #(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int CW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [CW-1:0] cfg_lead,
    input  logic [CW-1:0] cfg_active,
    input  logic [CW-1:0] cfg_trail,
    input  logic          cfg_rdy_async,
    input  logic          bus_rdy,
    output logic          bus_cs_n,
    output logic          bus_we_n,
    output logic          bus_rnw,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dq_o,
    output logic          bus_dq_oe,
    output logic          wr_done
);

    logic          idle;
    logic          start;
    logic          rdy_eff;
    logic [CW-1:0] lead_ld;
    logic [CW-1:0] act_q;
    logic [CW-1:0] trail_q;
    logic          async_q;

    assign req_ready = idle;
    assign start     = req_valid & idle;

    ext_wr_cfg_latch #(.AW(AW), .DW(DW), .CW(CW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .lead_in  (cfg_lead),
        .act_in   (cfg_active),
        .trail_in (cfg_trail),
        .async_in (cfg_rdy_async),
        .addr_in  (req_addr),
        .data_in  (req_data),
        .lead_ld  (lead_ld),
        .act_q    (act_q),
        .trail_q  (trail_q),
        .async_q  (async_q),
        .addr_q   (bus_addr),
        .data_q   (bus_dq_o)
    );

    ext_wr_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
        .clk        (clk),
        .rst_n      (rst_n),
        .rdy_raw    (bus_rdy),
        .async_mode (async_q),
        .rdy_eff    (rdy_eff)
    );

    ext_wr_fsm #(.CW(CW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .lead_ld (lead_ld),
        .act_q   (act_q),
        .trail_q (trail_q),
        .rdy_eff (rdy_eff),
        .idle    (idle),
        .cs_n    (bus_cs_n),
        .we_n    (bus_we_n),
        .rnw     (bus_rnw),
        .dq_oe   (bus_dq_oe),
        .done    (wr_done)
    );

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable(bus_addr)); // R7

    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dq_oe |-> (!bus_rnw && !bus_cs_n)); // R3

    AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dq_oe && $past(bus_dq_oe)) |-> $stable(bus_dq_o)); // R4

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> !req_ready); // R9

endmodule

// File: tb/ext_wr_seq_test.sv
`timescale 1ns/1ps
module ext_wr_seq_test;

    typedef struct packed {
        logic [3:0]  lead;
        logic [3:0]  act;
        logic [3:0]  trail;
        logic        asy;
        logic [7:0]  rdy_at;   // 0: ready already high; else edge at which it rises
        logic [15:0] addr;
        logic [15:0] data;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 4'd3, 4'd2, 1'b0, 8'd5, 16'h1234, 16'hA5A5},
        '{4'd1, 4'd1, 4'd1, 1'b0, 8'd5, 16'h00F0, 16'h5A5A},
        '{4'd3, 4'd2, 4'd3, 1'b1, 8'd0, 16'hBEEF, 16'h0001},
        '{4'd2, 4'd2, 4'd1, 1'b1, 8'd4, 16'h4000, 16'hFFFF},
        '{4'd0, 4'd0, 4'd0, 1'b0, 8'd0, 16'h0777, 16'h1357},
        '{4'd4, 4'd1, 4'd2, 1'b1, 8'd3, 16'h8001, 16'h2468},
        '{4'd1, 4'd2, 4'd1, 1'b0, 8'd4, 16'h00AA, 16'hC3C3},
        '{4'd2, 4'd2, 4'd2, 1'b1, 8'd3, 16'h7FFE, 16'h0F0F},
        '{4'd2, 4'd2, 4'd2, 1'b0, 8'd3, 16'h3C3C, 16'hF00F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [3:0]  cfg_lead = '0;
    logic [3:0]  cfg_active = '0;
    logic [3:0]  cfg_trail = '0;
    logic        cfg_rdy_async = 1'b0;
    logic        bus_rdy = 1'b1;
    logic        bus_cs_n, bus_we_n, bus_rnw, bus_dq_oe, wr_done;
    logic [15:0] bus_addr, bus_dq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ext_wr_seq uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_data      (req_data),
        .cfg_lead      (cfg_lead),
        .cfg_active    (cfg_active),
        .cfg_trail     (cfg_trail),
        .cfg_rdy_async (cfg_rdy_async),
        .bus_rdy       (bus_rdy),
        .bus_cs_n      (bus_cs_n),
        .bus_we_n      (bus_we_n),
        .bus_rnw       (bus_rnw),
        .bus_addr      (bus_addr),
        .bus_dq_o      (bus_dq_o),
        .bus_dq_oe     (bus_dq_oe),
        .wr_done       (wr_done)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic run_access(input vec_t v);
        int l, a, t, w, tot, r;
        string tw, tc;
        l = (v.lead  == 0) ? 1 : int'(v.lead);
        a = (v.act   == 0) ? 1 : int'(v.act);
        t = (v.trail == 0) ? 1 : int'(v.trail);
        r = int'(v.rdy_at);
        w = v.asy ? (r + 2 - (l + a)) : (r - (l + a));
        if (r == 0 || w < 0) w = 0;
        tot = l + a + w + t;
        tw = v.asy ? "R6" : "R5";
        tc = (v.lead == 0 || v.act == 0 || v.trail == 0) ? "R8" : "R2";
        @(negedge clk);
        bus_rdy = (r == 0);
        repeat (3) @(negedge clk);
        cfg_lead = v.lead; cfg_active = v.act; cfg_trail = v.trail;
        cfg_rdy_async = v.asy; req_addr = v.addr; req_data = v.data;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= tot + 1; k++) begin
            chk(tc,   "cs_n",      int'(bus_cs_n), (k <= tot) ? 0 : 1);
            chk(tw,   "we_n",      int'(bus_we_n), (k > l && k <= l + a + w) ? 0 : 1);
            chk("R3", "rnw",       int'(bus_rnw),  (k <= tot) ? 0 : 1);
            chk("R4", "dq_oe",     int'(bus_dq_oe), (k > l && k <= tot) ? 1 : 0);
            if (k > l && k <= tot) chk("R4", "dq", int'(bus_dq_o), int'(v.data));
            chk("R9", "done",      int'(wr_done),   (k == tot) ? 1 : 0);
            chk("R9", "req_ready", int'(req_ready), (k > tot) ? 1 : 0);
            chk("R10", "addr",     int'(bus_addr),  int'(v.addr));
            if (k == 1) begin
                // r10_ scramble captured inputs during the transfer
                cfg_lead = 4'hF; cfg_active = 4'hF; cfg_trail = 4'hF;
                cfg_rdy_async = ~v.asy; req_addr = ~v.addr; req_data = ~v.data;
            end
            if (k == r) bus_rdy = 1'b1;
            if (k <= tot) @(negedge clk);
        end
        req_addr = v.addr ^ 16'h5555;
        repeat (2) @(negedge clk);
        chk("R7", "addr idle hold", int'(bus_addr), int'(v.addr));
        chk("R7", "oe idle", int'(bus_dq_oe), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "cs_n rst",  int'(bus_cs_n), 1);
        chk("R1", "oe rst",    int'(bus_dq_oe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "cs_n",      int'(bus_cs_n), 1);
        chk("R1", "we_n",      int'(bus_we_n), 1);
        chk("R1", "rnw",       int'(bus_rnw), 1);
        chk("R1", "oe",        int'(bus_dq_oe), 0);
        chk("R1", "done",      int'(wr_done), 0);
        chk("R1", "req_ready", int'(req_ready), 1);
        chk("R1", "addr",      int'(bus_addr), 0);

        for (int i = 0; i < NV; i++) run_access(VECS[i]);

        // R9 back-to-back: valid held through done, second accept one cycle later
        bus_rdy = 1'b1;
        cfg_lead = 4'd1; cfg_active = 4'd1; cfg_trail = 4'd1; cfg_rdy_async = 1'b0;
        req_addr = 16'h0101; req_data = 16'h0202;
        repeat (2) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 3; k++) begin
            chk("R9", "b2b ready low", int'(req_ready), 0);
            chk("R9", "b2b done", int'(wr_done), (k == 3) ? 1 : 0);
            if (k == 3) begin req_addr = 16'h0303; req_data = 16'h0404; end
            @(negedge clk);
        end
        chk("R9", "b2b gap cs_n", int'(bus_cs_n), 1);
        chk("R9", "b2b gap ready", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "b2b second cs_n", int'(bus_cs_n), 0);
        chk("R9", "b2b second addr", int'(bus_addr), 16'h0303);
        repeat (6) @(negedge clk);
        chk("R9", "b2b idle", int'(req_ready), 1);

        // R1 reset in the middle of a transfer
        cfg_lead = 4'd3; cfg_active = 4'd3;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "mid reset cs_n", int'(bus_cs_n), 1);
        chk("R1", "mid reset addr", int'(bus_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "after reset ready", int'(req_ready), 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule